// File: doc/BRIEF.md
# Windowed Multithreaded Register File

This block holds the integer registers of many hardware threads in one shared storage array. Each thread owns a 64-slot region. Slot positions are fixed: slot 0 is the zero register, slots 1..7 hold the globals, and then come `WINDOWS` register windows of 16 slots each. With three windows, slots 56..63 are left free for other per-thread state. On every access, the 5-bit register number is translated to a physical slot using the thread's current window pointer. The "out" registers of a window share storage with the "in" registers of the window below it, so a caller's outs become the callee's ins when the pointer moves.

In each cycle a pipeline can issue one read pair and one write-back. A read pair carries:
- one thread id;
- one window pointer;
- two register numbers.

The two operands come back together exactly two cycles later. The physical address is the thread id placed above the 6-bit slot number. The block does no forwarding. A read in the same cycle as a write to the same slot returns the value held before the write. The issuing pipeline schedules threads so that this never matters.

Data flow is valid-qualified. `rd_valid` starts a read pair and `wr_en` starts a write-back. The block has no back-pressure: it accepts a request in every cycle, and it presents each result on `out_valid` for one cycle only, so the consumer must take it then. While `out_valid` is low, both data outputs are zero.

Top module: `windowed_regfile`

## Requirements
- R1: A read pair presented with `rd_valid` high in cycle t appears with `out_valid` high in cycle t+2.
- R2: Read pairs can be issued in back-to-back cycles, and each returns its own operands in issue order.
- R3: Register 0 of every thread and window reads as zero, and a write to register 0 changes nothing.
- R4: Registers 1..7 are globals, shared by all windows of a thread: a value written under one window pointer reads back under any other.
- R5: Registers 16..23 (locals) and 24..31 (ins) are private to the window named by the pointer. The pointer must stay below `WINDOWS` on both the read side and the write side.
- R6: Register 8+k (out k) under pointer w is the same storage as register 24+k (in k) under pointer (w-1) mod `WINDOWS`, and the wrap from window 0 to window `WINDOWS`-1 is included.
- R7: The same register number under different thread ids names separate storage.
- R8: A read issued in the same cycle as a write to the same slot returns the old value. A read issued one cycle later returns the new value.
- R9: During reset and after it, `out_valid` is low. Whenever `out_valid` is low, both data outputs are zero.
- R10: The two read ports are independent: the two ports may name different registers or the same register, and each returns its own value.
- R11: Each accepted read pair produces exactly one `out_valid` cycle, and no result appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_valid | input | 1 | Starts a read pair this cycle |
| rd_tid | input | TID_W | Thread id of the read pair |
| rd_cwp | input | CWP_W | Window pointer of the read pair |
| rd_reg_a | input | 5 | Register number, read port A |
| rd_reg_b | input | 5 | Register number, read port B |
| wr_en | input | 1 | Write-back strobe |
| wr_tid | input | TID_W | Thread id of the write |
| wr_cwp | input | CWP_W | Window pointer of the write |
| wr_reg | input | 5 | Register number of the write |
| wr_data | input | DATA_W | Write-back value |
| out_valid | output | 1 | Operand pair valid this cycle |
| out_data_a | output | DATA_W | Operand from port A |
| out_data_b | output | DATA_W | Operand from port B |

## Verification
The bench builds the block with `THREADS` = 4 and `WINDOWS` = 3. This gives a 256-entry array that a bench can fill completely and then read back under every thread, pointer and register number. The three-window setting exercises the wrap from window 0 to window 2, where the outs alias the ins of the top window. With four threads, an isolation check can write to one thread and confirm that a neighbour's slot is untouched. Directed cycles cover the same-cycle write-and-read, register 0 writes, and reads spaced by idle cycles.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int SLOT_W       = 6;
  localparam int CTX_SLOTS    = 1 << SLOT_W;
  localparam int GLOBAL_SLOTS = 8;
  localparam int WIN_SLOTS    = 16;
  localparam int REG_W        = 5;

  typedef logic [REG_W-1:0]  arch_reg_t;
  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'b00,
    GRP_OUT    = 2'b01,
    GRP_LOCAL  = 2'b10,
    GRP_IN     = 2'b11
  } reg_group_e;
endpackage

// File: rtl/wrf_slot_map.sv
module wrf_slot_map
  import wrf_pkg::*;
#(
  parameter int WINDOWS = 3,
  parameter int CWP_W   = 2
) (
  input  logic [CWP_W-1:0] cwp,
  input  arch_reg_t        areg,
  output slot_t            slot,
  output logic             is_zero
);
  int cur_w;
  int prev_w;
  int slot_i;
  reg_group_e grp;

  always_comb begin
    cur_w  = int'(cwp);
    prev_w = (cur_w == 0) ? (WINDOWS - 1) : (cur_w - 1);
    grp    = reg_group_e'(areg[4:3]);
    case (grp)
      GRP_GLOBAL: slot_i = int'(areg[2:0]);
      GRP_OUT:    slot_i = GLOBAL_SLOTS + WIN_SLOTS * prev_w + 8 + int'(areg[2:0]);
      GRP_LOCAL:  slot_i = GLOBAL_SLOTS + WIN_SLOTS * cur_w + int'(areg[2:0]);
      default:    slot_i = GLOBAL_SLOTS + WIN_SLOTS * cur_w + 8 + int'(areg[2:0]);
    endcase
    slot    = slot_i[SLOT_W-1:0];
    is_zero = (areg == '0);
  end
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
  parameter int DEPTH  = 2048,
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int RPORTS = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr [RPORTS],
  output logic [DATA_W-1:0] rdata [RPORTS]
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < RPORTS; p++) begin : g_rport
    always_ff @(posedge clk) begin
      rdata[p] <= mem[raddr[p]];
    end
  end
endmodule

// File: rtl/wrf_out_stage.sv
module wrf_out_stage #(
  parameter int DATA_W = 32,
  parameter int RPORTS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_zero [RPORTS],
  input  logic [DATA_W-1:0] mem_data [RPORTS],
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data [RPORTS]
);
  logic s1_valid;
  logic s1_zero [RPORTS];

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= req_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) res_valid <= 1'b0;
    else     res_valid <= s1_valid;
  end

  for (genvar p = 0; p < RPORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) s1_zero[p] <= 1'b1;
      else     s1_zero[p] <= req_zero[p];
    end
    always_ff @(posedge clk) begin
      if (rst)                        res_data[p] <= '0;
      else if (s1_valid && !s1_zero[p]) res_data[p] <= mem_data[p];
      else                            res_data[p] <= '0;
    end
  end
endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile
  import wrf_pkg::*;
#(
  parameter int THREADS = 32,
  parameter int WINDOWS = 3,
  parameter int DATA_W  = 32,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int CWP_W  = (WINDOWS > 1) ? $clog2(WINDOWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  input  logic [TID_W-1:0]  rd_tid,
  input  logic [CWP_W-1:0]  rd_cwp,
  input  logic [4:0]        rd_reg_a,
  input  logic [4:0]        rd_reg_b,
  input  logic              wr_en,
  input  logic [TID_W-1:0]  wr_tid,
  input  logic [CWP_W-1:0]  wr_cwp,
  input  logic [4:0]        wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data_a,
  output logic [DATA_W-1:0] out_data_b
);
  localparam int RPORTS = 2;
  localparam int ADDR_W = TID_W + SLOT_W;
  localparam int DEPTH  = THREADS * CTX_SLOTS;

  arch_reg_t         rd_reg   [RPORTS];
  slot_t             rd_slot  [RPORTS];
  logic              rd_zero  [RPORTS];
  logic [ADDR_W-1:0] rd_addr  [RPORTS];
  logic [DATA_W-1:0] mem_data [RPORTS];
  logic [DATA_W-1:0] res_data [RPORTS];

  slot_t             wr_slot;
  logic              wr_zero;
  logic [ADDR_W-1:0] wr_addr;
  logic              wr_commit;

  assign rd_reg[0] = rd_reg_a;
  assign rd_reg[1] = rd_reg_b;

  for (genvar p = 0; p < RPORTS; p++) begin : g_rmap
    wrf_slot_map #(.WINDOWS(WINDOWS), .CWP_W(CWP_W)) u_map (
      .cwp     (rd_cwp),
      .areg    (rd_reg[p]),
      .slot    (rd_slot[p]),
      .is_zero (rd_zero[p])
    );
    assign rd_addr[p] = {rd_tid, rd_slot[p]};
  end

  wrf_slot_map #(.WINDOWS(WINDOWS), .CWP_W(CWP_W)) u_wmap (
    .cwp     (wr_cwp),
    .areg    (wr_reg),
    .slot    (wr_slot),
    .is_zero (wr_zero)
  );

  assign wr_addr   = {wr_tid, wr_slot};
  assign wr_commit = wr_en && !wr_zero && !rst;

  wrf_store #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .RPORTS(RPORTS)
  ) u_store (
    .clk   (clk),
    .we    (wr_commit),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (mem_data)
  );

  wrf_out_stage #(.DATA_W(DATA_W), .RPORTS(RPORTS)) u_out (
    .clk       (clk),
    .rst       (rst),
    .req_valid (rd_valid),
    .req_zero  (rd_zero),
    .mem_data  (mem_data),
    .res_valid (out_valid),
    .res_data  (res_data)
  );

  assign out_data_a = res_data[0];
  assign out_data_b = res_data[1];
endmodule

// File: rtl/windowed_regfile_checker.sv
module windowed_regfile_checker #(
  parameter int WINDOWS = 3,
  parameter int DATA_W  = 32,
  parameter int CWP_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_valid,
  input logic [CWP_W-1:0]  rd_cwp,
  input logic [4:0]        rd_reg_a,
  input logic [4:0]        rd_reg_b,
  input logic              wr_en,
  input logic [CWP_W-1:0]  wr_cwp,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data_a,
  input logic [DATA_W-1:0] out_data_b
);
  logic chk_v1, chk_v2;
  logic chk_za1, chk_za2, chk_zb1, chk_zb2;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_v1  <= 1'b0;
      chk_v2  <= 1'b0;
      chk_za1 <= 1'b0;
      chk_za2 <= 1'b0;
      chk_zb1 <= 1'b0;
      chk_zb2 <= 1'b0;
    end else begin
      chk_v1  <= rd_valid;
      chk_v2  <= chk_v1;
      chk_za1 <= (rd_reg_a == 5'd0);
      chk_za2 <= chk_za1;
      chk_zb1 <= (rd_reg_b == 5'd0);
      chk_zb2 <= chk_zb1;
    end
  end

  // R1
  a_r1_two_cycle: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> ##1 out_valid);

  // R11
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> chk_v2);

  // R3
  a_r3_zero_port_a: assert property (@(posedge clk) disable iff (rst)
    (chk_v2 && chk_za2) |-> (out_data_a == '0));

  a_r3_zero_port_b: assert property (@(posedge clk) disable iff (rst)
    (chk_v2 && chk_zb2) |-> (out_data_b == '0));

  // R9
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data_a == '0 && out_data_b == '0));

  // R5
  a_r5_rd_cwp_legal: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (int'(rd_cwp) < WINDOWS));

  a_r5_wr_cwp_legal: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_cwp) < WINDOWS));
endmodule

bind windowed_regfile windowed_regfile_checker #(
  .WINDOWS(WINDOWS),
  .DATA_W (DATA_W),
  .CWP_W  (CWP_W)
) u_wrf_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_valid   (rd_valid),
  .rd_cwp     (rd_cwp),
  .rd_reg_a   (rd_reg_a),
  .rd_reg_b   (rd_reg_b),
  .wr_en      (wr_en),
  .wr_cwp     (wr_cwp),
  .out_valid  (out_valid),
  .out_data_a (out_data_a),
  .out_data_b (out_data_b)
);

// File: tb/tb_windowed_regfile.sv
module tb_windowed_regfile;
  localparam int THREADS = 4;
  localparam int WIN     = 3;
  localparam int DW      = 32;
  localparam int TID_W   = 2;
  localparam int CWP_W   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_valid = 1'b0;
  logic [TID_W-1:0] rd_tid = '0;
  logic [CWP_W-1:0] rd_cwp = '0;
  logic [4:0] rd_reg_a = '0, rd_reg_b = '0;
  logic wr_en = 1'b0;
  logic [TID_W-1:0] wr_tid = '0;
  logic [CWP_W-1:0] wr_cwp = '0;
  logic [4:0] wr_reg = '0;
  logic [DW-1:0] wr_data = '0;
  logic out_valid;
  logic [DW-1:0] out_data_a, out_data_b;

  always #2ns clk = ~clk;

  windowed_regfile #(.THREADS(THREADS), .WINDOWS(WIN), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst),
    .rd_valid(rd_valid), .rd_tid(rd_tid), .rd_cwp(rd_cwp),
    .rd_reg_a(rd_reg_a), .rd_reg_b(rd_reg_b),
    .wr_en(wr_en), .wr_tid(wr_tid), .wr_cwp(wr_cwp),
    .wr_reg(wr_reg), .wr_data(wr_data),
    .out_valid(out_valid), .out_data_a(out_data_a), .out_data_b(out_data_b)
  );

  typedef struct {
    int          issue;
    logic [31:0] a;
    logic [31:0] b;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] model [THREADS][64];
  int          cyc = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Independent view of where a register lives inside a thread's region.
  function automatic int bslot(int cwp, int r);
    if (r < 8)   return r;
    if (r >= 24) return 16 + 16 * cwp + (r - 24);
    if (r >= 16) return 8 + 16 * cwp + (r - 16);
    return 16 + 16 * ((cwp + WIN - 1) % WIN) + (r - 8);
  endfunction

  function automatic logic [31:0] bread(int tid, int cwp, int r);
    if (r == 0) return 32'h0;
    return model[tid][bslot(cwp, r)];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: one cycle of stimulus, expectations pushed before the write lands.
  task automatic drive(bit rv, int rt, int rc, int ra, int rb,
                       bit we, int wt, int wc, int wr, logic [31:0] wd,
                       string tag);
    exp_t e;
    rd_valid = rv; rd_tid = TID_W'(rt); rd_cwp = CWP_W'(rc);
    rd_reg_a = 5'(ra); rd_reg_b = 5'(rb);
    wr_en = we; wr_tid = TID_W'(wt); wr_cwp = CWP_W'(wc);
    wr_reg = 5'(wr); wr_data = wd;
    if (rv) begin
      e.issue = cyc;
      e.a = bread(rt, rc, ra);
      e.b = bread(rt, rc, rb);
      e.tag = tag;
      sb_q.push_back(e);
    end
    if (we && wr != 0) model[wt][bslot(wc, wr)] = wd;
    @(negedge clk);
  endtask

  task automatic rd(int t, int c, int a, int b, string tag);
    drive(1, t, c, a, b, 0, 0, 0, 0, 32'h0, tag);
  endtask

  task automatic wr(int t, int c, int r, logic [31:0] d);
    drive(0, 0, 0, 0, 0, 1, t, c, r, d, "");
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, "");
  endtask

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R11 unexpected result", out_data_a, 32'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(cyc == e.issue + 2, "R1 latency", 32'(cyc), 32'(e.issue + 2));
          check(out_data_a === e.a, {e.tag, " port A"}, out_data_a, e.a);
          check(out_data_b === e.b, {e.tag, " port B"}, out_data_b, e.b);
        end
      end else begin
        if (sb_q.size() != 0 && sb_q[0].issue + 2 == cyc)
          check(1'b0, "R1 result missing", 32'h0, sb_q[0].a);
        if (out_data_a !== 32'h0 || out_data_b !== 32'h0)
          check(1'b0, "R9 idle data nonzero", out_data_a | out_data_b, 32'h0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < THREADS; t++)
      for (int s = 0; s < 64; s++) model[t][s] = 32'h0;

    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R9 reset valid", 32'(out_valid), 32'h0);
    check(out_data_a === 32'h0 && out_data_b === 32'h0, "R9 reset data",
          out_data_a | out_data_b, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R9 post-reset valid", 32'(out_valid), 32'h0);

    // Fill every register of every thread under every window pointer.
    for (int t = 0; t < THREADS; t++)
      for (int c = 0; c < WIN; c++)
        for (int r = 1; r < 32; r++)
          wr(t, c, r, {8'(t), 8'(c), 8'(r), 8'h3c} ^ 32'h9e37_0000);

    // R2 / R10: back-to-back sweep, two different registers per pair.
    for (int t = 0; t < THREADS; t++)
      for (int c = 0; c < WIN; c++)
        for (int r = 0; r < 32; r++)
          rd(t, c, r, 31 - r, "R2 R10 sweep");
    idle(3);

    // R3: write to register 0 is dropped, reads stay zero.
    wr(1, 1, 0, 32'hdead_beef);
    rd(1, 1, 0, 0, "R3 zero register");
    rd(1, 2, 0, 5, "R3 zero register");

    // R4: global written under window 2, read under windows 0 and 1.
    wr(2, 2, 5, 32'h0bad_0005);
    rd(2, 0, 5, 5, "R4 global shared");
    rd(2, 1, 5, 0, "R4 global shared");

    // R5: local in window 0 does not show in window 1.
    wr(0, 0, 17, 32'h1111_0017);
    rd(0, 1, 17, 25, "R5 window private");
    rd(0, 0, 17, 17, "R5 window private");

    // R6: out of window 0 is the in of window 2 (wrap), and in of 0 is out of 1.
    wr(1, 0, 8, 32'ha1a1_0008);
    wr(1, 0, 31, 32'ha1a1_0031);
    rd(1, 2, 24, 24, "R6 wrap alias");
    rd(1, 1, 15, 8, "R6 alias");

    // R7: same register in another thread is separate.
    wr(2, 1, 20, 32'h7777_0020);
    rd(3, 1, 20, 20, "R7 thread isolation");
    rd(2, 1, 20, 20, "R7 thread isolation");

    // R8: same-cycle write and read returns the old value, next read the new.
    drive(1, 0, 1, 9, 9, 1, 0, 1, 9, 32'h8888_0009, "R8 old value");
    rd(0, 1, 9, 9, "R8 new value");

    // R11 / R1: reads with gaps between them.
    rd(3, 2, 30, 1, "R11 spaced");
    idle(1);
    rd(3, 0, 12, 19, "R11 spaced");
    idle(2);
    rd(2, 1, 6, 22, "R11 spaced");

    idle(4);
    check(sb_q.size() == 0, "R11 results outstanding", 32'(sb_q.size()), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule